// File: doc/BRIEF.md
# Zero-Detect Mute and Soft-Start Sequencer

This block sequences the output stage of a single-supply stereo converter and drives the external mute line. While reset is held low, the block is in a power-down phase. In that phase the outputs are clamped and audio is blocked. Once reset is released, the clamp stays on for a fixed number of frame periods. After that, a digital level climbs from zero toward the quiescent point, one step per frame period. Audio is passed only when the climb is complete.

In parallel, the block watches the incoming stereo sample stream. When enough consecutive samples arrive in which both channels are static zero or static all-ones, it raises mute. The first sample with real content on either channel releases mute. Mute is also forced high whenever the sequencer is not running audio, and for as long as the clock-ratio-error flag is set.

The sample input is a valid-only stream. No ready is returned, and a sample is consumed on every clock in which `smp_valid` is high. The block therefore never applies back-pressure, and the producer must not expect to be stalled. Cycles with `smp_valid` low are neither counted as idle nor treated as activity.

Top module: `dac_mute_softstart`

## Requirements
- R1: While `rst_n` is low, `clamp_en` is 1, `ramp_lvl` is 0, `audio_en` is 0 and `mute` is 1.
- R2: After `rst_n` rises, `clamp_en` stays 1 and `ramp_lvl` stays 0 until CLAMP_FRAMES (default 1000) frame ticks have been seen; the tick that completes the count clears `clamp_en`.
- R3: During the climb, an internal RAMP_BITS-wide (default 14) step count advances by one on each frame tick, and `ramp_lvl` shows its top RAMP_OUT_W (default 8) bits. No output of the sequencer changes on a clock without a frame tick.
- R4: `audio_en` rises only on the frame tick after the step count has reached all ones, that is after 2^RAMP_BITS climb ticks. While `audio_en` is 1, `ramp_lvl` is all ones and `clamp_en` is 0.
- R5: Pulling `rst_n` low while audio runs drops `audio_en` and raises `clamp_en` and `mute` without waiting for a clock edge. After the next release, the clamp phase starts over.
- R6: `mute` is 1 in every cycle in which `audio_en` is 0.
- R7: `ratio_err` high forces `mute` to 1 in the same cycle, leaves `audio_en` unchanged, and discards any idle run counted so far.
- R8: `mute` rises once IDLE_RUN (default 8192) valid samples in a row have both channel words equal to all zeros or all ones. The two channels may differ in which of the two values they hold. Cycles without `smp_valid` do not break the run.
- R9: A valid sample in which either channel word is neither all zeros nor all ones clears `mute` from the next cycle on, provided audio runs and `ratio_err` is low, and restarts the run from zero.
- R10: Once the idle run has reached IDLE_RUN, further idle samples keep `mute` at 1; the run count does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset; low means power-down |
| frame_tick | input | 1 | One-cycle strobe per frame (sample) period |
| smp_valid | input | 1 | Sample words are present this cycle |
| smp_left | input | SW (24) | Left channel word, two's complement |
| smp_right | input | SW (24) | Right channel word, two's complement |
| ratio_err | input | 1 | Clock-ratio-error flag from the clock monitor |
| clamp_en | output | 1 | Hold the outputs at ground |
| ramp_lvl | output | RAMP_OUT_W (8) | Digital level driven toward the quiescent point |
| audio_en | output | 1 | Pass audio to the output stage |
| mute | output | 1 | Drive for the external mute circuit |

## Verification
On every cycle, the assertions check the relations that hold without history. These are the reset outputs, mute whenever audio is off or the ratio flag is set, a zero level while clamped, a full level while running, a frozen sequencer on clocks without a frame tick, and the release of mute one cycle after an active sample. The exact clamp and climb lengths, the 8192-sample idle threshold including its one-short boundary, the tolerance of gaps in the valid stream, saturation of the run count and the discard of a run by a ratio error all depend on long counts. The bench's scenarios, checked against its behavioural model, are the only place these show.

// File: rtl/dac_mute_softstart_pkg.sv
package dac_mute_softstart_pkg;

  // Output-stage sequencing phases, in power-up order.
  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_HOLD = 2'd1,
    PH_RISE = 2'd2,
    PH_LIVE = 2'd3
  } phase_t;

endpackage

// File: rtl/word_idle_cmp.sv
module word_idle_cmp #(
  parameter int SW = 24
) (
  input  logic [SW-1:0] word,
  output logic          idle
);

  // Static silence is either all zeros or all ones (minus one LSB).
  assign idle = (word == '0) || (word == '1);

endmodule

// File: rtl/idle_run_det.sv
module idle_run_det #(
  parameter int SW       = 24,
  parameter int IDLE_RUN = 8192
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp_left,
  input  logic [SW-1:0] smp_right,
  input  logic          clr,
  output logic          run_hit
);

  localparam int NCH = 2;
  localparam int IW  = $clog2(IDLE_RUN + 1);

  logic [NCH-1:0][SW-1:0] words;
  logic [NCH-1:0]         ch_idle;
  logic [IW-1:0]          run_cnt;

  assign words[0] = smp_left;
  assign words[1] = smp_right;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    word_idle_cmp #(.SW(SW)) u_cmp (
      .word (words[ch]),
      .idle (ch_idle[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (clr) begin
      run_cnt <= '0;
    end else if (smp_valid) begin
      if (&ch_idle) begin
        if (run_cnt != IW'(IDLE_RUN)) run_cnt <= run_cnt + 1'b1;
      end else begin
        run_cnt <= '0;
      end
    end
  end

  assign run_hit = (run_cnt == IW'(IDLE_RUN));

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import dac_mute_softstart_pkg::*;
#(
  parameter int CLAMP_FRAMES = 1000,
  parameter int RAMP_BITS    = 14,
  parameter int RAMP_OUT_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_tick,
  output phase_t                phase,
  output logic [RAMP_OUT_W-1:0] ramp_lvl
);

  localparam int CW = (CLAMP_FRAMES > 1) ? $clog2(CLAMP_FRAMES) : 1;

  logic [CW-1:0]        hold_cnt;
  logic [RAMP_BITS-1:0] rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_OFF;
      hold_cnt <= '0;
      rise_cnt <= '0;
    end else begin
      unique case (phase)
        PH_OFF: phase <= PH_HOLD;
        PH_HOLD: begin
          if (frame_tick) begin
            if (hold_cnt == CW'(CLAMP_FRAMES - 1)) begin
              phase    <= PH_RISE;
              hold_cnt <= '0;
            end else begin
              hold_cnt <= hold_cnt + 1'b1;
            end
          end
        end
        PH_RISE: begin
          if (frame_tick) begin
            if (rise_cnt == '1) phase <= PH_LIVE;
            else                rise_cnt <= rise_cnt + 1'b1;
          end
        end
        PH_LIVE: phase <= PH_LIVE;
        default: phase <= PH_OFF;
      endcase
    end
  end

  // Step count is zero before the climb and saturated after it.
  assign ramp_lvl = rise_cnt[RAMP_BITS-1 -: RAMP_OUT_W];

endmodule

// File: rtl/dac_mute_softstart.sv
module dac_mute_softstart
  import dac_mute_softstart_pkg::*;
#(
  parameter int SW           = 24,
  parameter int CLAMP_FRAMES = 1000,
  parameter int RAMP_BITS    = 14,
  parameter int RAMP_OUT_W   = 8,
  parameter int IDLE_RUN     = 8192
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_tick,
  input  logic                  smp_valid,
  input  logic [SW-1:0]         smp_left,
  input  logic [SW-1:0]         smp_right,
  input  logic                  ratio_err,
  output logic                  clamp_en,
  output logic [RAMP_OUT_W-1:0] ramp_lvl,
  output logic                  audio_en,
  output logic                  mute
);

  phase_t phase;
  logic   run_hit;

  softstart_seq #(
    .CLAMP_FRAMES (CLAMP_FRAMES),
    .RAMP_BITS    (RAMP_BITS),
    .RAMP_OUT_W   (RAMP_OUT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .phase      (phase),
    .ramp_lvl   (ramp_lvl)
  );

  idle_run_det #(
    .SW       (SW),
    .IDLE_RUN (IDLE_RUN)
  ) u_idle (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_left  (smp_left),
    .smp_right (smp_right),
    .clr       (ratio_err),
    .run_hit   (run_hit)
  );

  assign clamp_en = (phase == PH_OFF) || (phase == PH_HOLD);
  assign audio_en = (phase == PH_LIVE);
  assign mute     = (phase != PH_LIVE) || ratio_err || run_hit;

endmodule

// File: rtl/dac_mute_softstart_chk.sv
module dac_mute_softstart_chk #(
  parameter int SW         = 24,
  parameter int RAMP_OUT_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  frame_tick,
  input logic                  smp_valid,
  input logic [SW-1:0]         smp_left,
  input logic [SW-1:0]         smp_right,
  input logic                  ratio_err,
  input logic                  clamp_en,
  input logic [RAMP_OUT_W-1:0] ramp_lvl,
  input logic                  audio_en,
  input logic                  mute
);

  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  logic active_smp;
  assign active_smp = smp_valid &&
                      !(((smp_left == '0) || (smp_left == '1)) &&
                        ((smp_right == '0) || (smp_right == '1)));

  // R1
  reset_outputs_chk: assert property (@(posedge clk)
    (started && !rst_n) |-> (clamp_en && mute && !audio_en && ramp_lvl == '0));

  // R2
  clamp_level_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_en |-> (ramp_lvl == '0));

  // R3
  frozen_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> ($stable(ramp_lvl) && $stable(clamp_en) && $stable(audio_en)));

  // R4
  live_full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    audio_en |-> (ramp_lvl == '1 && !clamp_en));

  // R6
  mute_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !audio_en |-> mute);

  // R7
  ratio_forces_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_err |-> mute);

  // R9
  active_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (audio_en && active_smp) |=> (mute == ratio_err));

endmodule

bind dac_mute_softstart dac_mute_softstart_chk #(
  .SW         (SW),
  .RAMP_OUT_W (RAMP_OUT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_tick (frame_tick),
  .smp_valid  (smp_valid),
  .smp_left   (smp_left),
  .smp_right  (smp_right),
  .ratio_err  (ratio_err),
  .clamp_en   (clamp_en),
  .ramp_lvl   (ramp_lvl),
  .audio_en   (audio_en),
  .mute       (mute)
);

// File: tb/sim_dac_mute_softstart.sv
module sim_dac_mute_softstart;

  localparam int CLK_PERIOD = 10;
  localparam int SW         = 24;
  localparam int CLAMP_N    = 1000;
  localparam int RBITS      = 14;
  localparam int ROUT       = 8;
  localparam int IDLE_N     = 8192;
  localparam int RAMP_MAX   = (1 << RBITS) - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            frame_tick = 1'b0;
  logic            smp_valid = 1'b0;
  logic [SW-1:0]   smp_left = '0;
  logic [SW-1:0]   smp_right = '0;
  logic            ratio_err = 1'b0;
  logic            clamp_en;
  logic [ROUT-1:0] ramp_lvl;
  logic            audio_en;
  logic            mute;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_mute_softstart #(
    .SW(SW), .CLAMP_FRAMES(CLAMP_N), .RAMP_BITS(RBITS),
    .RAMP_OUT_W(ROUT), .IDLE_RUN(IDLE_N)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right), .ratio_err(ratio_err),
    .clamp_en(clamp_en), .ramp_lvl(ramp_lvl), .audio_en(audio_en), .mute(mute)
  );

  // Behavioural reference: phase 0 off, 1 clamp, 2 climb, 3 running.
  int m_phase = 0;
  int m_clamp = 0;
  int m_ramp  = 0;
  int m_idle  = 0;

  function automatic bit is_idle(logic [SW-1:0] w);
    return (w == 0) || (w == {SW{1'b1}});
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_clamp = 0; m_ramp = 0; m_idle = 0;
    end else begin
      if (m_phase == 0) m_phase = 1;
      else if (m_phase == 1 && frame_tick) begin
        m_clamp++;
        if (m_clamp == CLAMP_N) m_phase = 2;
      end else if (m_phase == 2 && frame_tick) begin
        if (m_ramp == RAMP_MAX) m_phase = 3;
        else m_ramp++;
      end
      if (ratio_err) m_idle = 0;
      else if (smp_valid) begin
        if (is_idle(smp_left) && is_idle(smp_right)) begin
          if (m_idle < IDLE_N) m_idle++;
        end else m_idle = 0;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk("R2 clamp_en model", int'(clamp_en), (m_phase < 2) ? 1 : 0);
    chk("R3 ramp_lvl model", int'(ramp_lvl), m_ramp >> (RBITS - ROUT));
    chk("R4 audio_en model", int'(audio_en), (m_phase == 3) ? 1 : 0);
    chk("R6 mute model", int'(mute),
        ((m_phase != 3) || ratio_err || (m_idle >= IDLE_N)) ? 1 : 0);
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      step(); frame_tick = 1'b1;
      step(); frame_tick = 1'b0;
    end
  endtask

  task automatic put(input bit v, input logic [SW-1:0] l, input logic [SW-1:0] r);
    step();
    smp_valid = v; smp_left = l; smp_right = r;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    // R1: reset state with busy inputs
    smp_valid = 1'b1; smp_left = 24'h123456; ratio_err = 1'b0;
    frame_tick = 1'b1;
    for (int i = 0; i < 4; i++) step();
    chk("R1 clamp_en", int'(clamp_en), 1);
    chk("R1 ramp_lvl", int'(ramp_lvl), 0);
    chk("R1 audio_en", int'(audio_en), 0);
    chk("R1 mute", int'(mute), 1);
    frame_tick = 1'b0; smp_valid = 1'b0; smp_left = '0;
    rst_n = 1'b1;
    step();
    // R2: clamp lasts exactly CLAMP_N ticks
    ticks(CLAMP_N - 1);
    chk("R2 clamp before last tick", int'(clamp_en), 1);
    ticks(1);
    chk("R2 clamp released", int'(clamp_en), 0);
    chk("R2 level at climb start", int'(ramp_lvl), 0);
    // R3: one step per tick, frozen without ticks
    ticks(64);
    chk("R3 level after 64 steps", int'(ramp_lvl), 1);
    for (int i = 0; i < 7; i++) step();
    chk("R3 level frozen without tick", int'(ramp_lvl), 1);
    ticks(RAMP_MAX - 64);
    chk("R4 audio off at top count", int'(audio_en), 0);
    chk("R4 level full at top count", int'(ramp_lvl), 255);
    chk("R6 mute before running", int'(mute), 1);
    ticks(1);
    chk("R4 audio on", int'(audio_en), 1);
    chk("R6 mute released when running", int'(mute), 0);

    // R8: one short of the threshold, mixed zero and all-ones words
    for (int i = 0; i < IDLE_N - 1; i++)
      put(1'b1, (i % 2) ? '1 : '0, (i % 3 == 0) ? '0 : '1);
    step();
    chk("R8 mute low one short", int'(mute), 0);
    smp_left = '1; smp_right = '0;
    step();
    chk("R8 mute high at threshold", int'(mute), 1);
    // R10: saturation
    for (int i = 0; i < 10; i++) step();
    chk("R10 mute held past threshold", int'(mute), 1);
    // R9: active left word releases at once
    smp_left = 24'h000005;
    step();
    chk("R9 left active release", int'(mute), 0);
    chk("R9 audio still on", int'(audio_en), 1);

    // R8: gaps in the valid stream do not break the run
    begin
      int sent = 0;
      bit seen = 0;
      for (int i = 0; sent < IDLE_N; i++) begin
        step();
        if (sent == IDLE_N - 1 && !seen) begin
          chk("R8 gapped one short", int'(mute), 0);
          seen = 1;
        end
        smp_valid = (i % 7 != 3);
        smp_left = (i % 5 == 0) ? 24'h000001 : '0;
        smp_right = '1;
        if (!smp_valid) smp_left = 24'h0ABCDE;
        if (smp_valid && smp_left != 0) smp_left = '0;
        if (smp_valid) sent++;
      end
    end
    step();
    chk("R8 gapped threshold", int'(mute), 1);
    // R9: active right word
    smp_valid = 1'b1; smp_left = '0; smp_right = 24'h000100;
    step();
    chk("R9 right active release", int'(mute), 0);

    // R7: ratio error mutes at once and discards the run
    smp_right = '0;
    for (int i = 0; i < 8000; i++) step();
    smp_valid = 1'b0; ratio_err = 1'b1;
    #1;
    chk("R7 mute same cycle", int'(mute), 1);
    step();
    chk("R7 audio kept", int'(audio_en), 1);
    ratio_err = 1'b0; smp_valid = 1'b1;
    for (int i = 0; i < 8000; i++) step();
    chk("R7 run discarded", int'(mute), 0);
    for (int i = 0; i < 192; i++) step();
    step();
    chk("R8 threshold after discard", int'(mute), 1);
    smp_valid = 1'b0;

    // R5: reset while running
    step();
    rst_n = 1'b0;
    #1;
    chk("R5 audio dropped at once", int'(audio_en), 0);
    chk("R5 clamp at once", int'(clamp_en), 1);
    chk("R5 mute at once", int'(mute), 1);
    step(); step();
    rst_n = 1'b1;
    ticks(3);
    chk("R5 clamp restarted", int'(clamp_en), 1);
    chk("R5 level restarted", int'(ramp_lvl), 0);
    finish_run();
  end

endmodule